// File: doc/BRIEF.md
# Directory Coherence Controller for a Shared Last-Level Cache

This block keeps the coherence directory for a shared, write-back last-level cache that serves several write-through L1 caches. Every cache block has an entry with a state (uncached, shared or exclusive) and a sharer vector with one bit per core. Cores send read-miss, write-miss and write-back requests. For each request the controller updates the entry, answers the requester with data, and sends invalidate, fetch or fetch-and-invalidate messages to other cores when the protocol needs them.

Because the L1 caches write through, a core that only shares a block needs nothing but an invalidation. Only an exclusive owner can hold newer data than the shared cache. When a request hits an exclusive block, the controller fetches the data from the owner. It holds `busy` high until the owner's data returns, then writes that data into the shared cache and forwards it to the requester. The shared-cache data array is outside the block. It is reached through a combinational read port, which is addressed by the incoming request, and a registered write port.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset, `busy`, `rsp_valid`, `msg_valid` and `llc_wr_en` are low, and every directory entry is uncached with an empty sharer vector. A first request to any block therefore produces no message.
- R2: A read miss (`req_kind`=0) to an uncached block replies with the shared-cache data. The entry becomes shared, holding the requester alone (sharer bit i stands for core i).
- R3: A read miss to a shared block replies with the shared-cache data, adds the requester to the sharer vector and sends no message.
- R4: A write miss (`req_kind`=1) to an uncached block replies with data and sends no message. The entry becomes exclusive, with the requester as its only sharer.
- R5: A write miss to a shared block sends one invalidate message (`msg_kind`=1). Its `msg_dest` is every sharer except the requester, and the message is left out if that set is empty. The block replies with data, and the entry becomes exclusive with the requester only.
- R6: A read miss to an exclusive block sends a fetch (`msg_kind`=2) to the owner alone. When `own_valid` arrives, the owner data is written into the shared cache and returned to the requester. The entry becomes shared, holding both the old owner and the requester.
- R7: A write miss to an exclusive block sends a fetch-and-invalidate (`msg_kind`=3) to the owner. When the owner data arrives, it is written into the shared cache and returned to the requester. The entry stays exclusive, with the requester as the new owner.
- R8: A write-back (`req_kind`=2) from the owner of an exclusive block writes `req_wdata` into the shared cache and leaves the entry uncached and empty, with no reply. A write-back to a non-exclusive block, or from a core that is not the owner, changes nothing and produces no output.
- R9: `busy` is high from the cycle after a fetch is issued until the cycle after the owner data arrives. Requests presented while `busy` is high get no reply and no message.
- R10: `own_valid` while `busy` is low has no effect: no reply and no shared-cache write.
- R11: Reply, message and shared-cache write appear one cycle after a request is accepted. A read following a write to the same block in the next cycle returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_core | input | CW | Requesting core id |
| req_blk | input | BW | Block index |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 ignored |
| req_wdata | input | DW | Write-back data |
| busy | output | 1 | Waiting for owner data; requests are not accepted |
| msg_valid | output | 1 | Coherence message present |
| msg_kind | output | 2 | 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_dest | output | NCORES | Destination cores, one bit per core |
| msg_blk | output | BW | Block the message refers to |
| own_valid | input | 1 | Owner data returned |
| own_data | input | DW | Owner data |
| rsp_valid | output | 1 | Reply present |
| rsp_core | output | CW | Core the reply is for |
| rsp_data | output | DW | Reply data |
| llc_rd_blk | output | BW | Shared-cache read index (follows req_blk) |
| llc_rd_data | input | DW | Shared-cache read data, combinational |
| llc_wr_en | output | 1 | Shared-cache write strobe |
| llc_wr_blk | output | BW | Shared-cache write index |
| llc_wr_data | output | DW | Shared-cache write data |

## Verification
The assertions assume three things about the inputs. Core ids stay below the core count. The shared-cache read port returns the contents for `llc_rd_blk` in the same cycle. Owner data arrives only as the answer to a fetch. The stimulus keeps within these limits: it draws core ids in range, serves reads from a bench array that is updated only by the block's write strobe, and raises `own_valid` during a wait only after checking the fetch, apart from one directed pulse while idle that tests R10. The random mix leans toward write-backs from the real owner, so the uncached, shared and exclusive states all keep recurring.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

    typedef enum logic [1:0] {
        DIR_UNC = 2'd0,
        DIR_SHR = 2'd1,
        DIR_EXC = 2'd2
    } dir_st_e;

    typedef enum logic [1:0] {
        RQ_READ  = 2'd0,
        RQ_WRITE = 2'd1,
        RQ_WBACK = 2'd2,
        RQ_NONE  = 2'd3
    } rq_kind_e;

    typedef enum logic [1:0] {
        MS_NONE      = 2'd0,
        MS_INV       = 2'd1,
        MS_FETCH     = 2'd2,
        MS_FETCH_INV = 2'd3
    } msg_kind_e;

    // message sent to the owner of an exclusive block
    function automatic msg_kind_e owner_msg(rq_kind_e k);
        return (k == RQ_WRITE) ? MS_FETCH_INV : MS_FETCH;
    endfunction

endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store
    import coh_dir_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int NBLK   = 16,
    localparam int BW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BW-1:0]     rd_idx,
    output dir_st_e           rd_st,
    output logic [NCORES-1:0] rd_sh,
    input  logic              we,
    input  logic [BW-1:0]     wr_idx,
    input  dir_st_e           wr_st,
    input  logic [NCORES-1:0] wr_sh
);
    dir_st_e           st_q [NBLK];
    logic [NCORES-1:0] sh_q [NBLK];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBLK; i++) begin
                st_q[i] <= DIR_UNC;
                sh_q[i] <= '0;
            end
        end else if (we) begin
            st_q[wr_idx] <= wr_st;
            sh_q[wr_idx] <= wr_sh;
        end
    end

    assign rd_st = st_q[rd_idx];
    assign rd_sh = sh_q[rd_idx];

    // an exclusive entry names exactly one owner
    p_exc_one_owner_r4: assert property (@(posedge clk) disable iff (rst)
        (we && wr_st == DIR_EXC) |-> ($countones(wr_sh) == 1));
    // an uncached entry has no sharers
    p_unc_empty_r8: assert property (@(posedge clk) disable iff (rst)
        (we && wr_st == DIR_UNC) |-> (wr_sh == '0));
    // a shared entry is never empty
    p_shr_nonempty_r3: assert property (@(posedge clk) disable iff (rst)
        (we && wr_st == DIR_SHR) |-> (wr_sh != '0));
endmodule

// File: rtl/coh_dir_engine.sv
module coh_dir_engine
    import coh_dir_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int NBLK   = 16,
    parameter int DW     = 32,
    localparam int CW    = (NCORES > 1) ? $clog2(NCORES) : 1,
    localparam int BW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CW-1:0]     req_core,
    input  logic [BW-1:0]     req_blk,
    input  logic [1:0]        req_kind,
    input  logic [DW-1:0]     req_wdata,
    output logic              busy,
    output logic              msg_valid,
    output logic [1:0]        msg_kind,
    output logic [NCORES-1:0] msg_dest,
    output logic [BW-1:0]     msg_blk,
    input  logic              own_valid,
    input  logic [DW-1:0]     own_data,
    output logic              rsp_valid,
    output logic [CW-1:0]     rsp_core,
    output logic [DW-1:0]     rsp_data,
    output logic [BW-1:0]     llc_rd_blk,
    input  logic [DW-1:0]     llc_rd_data,
    output logic              llc_wr_en,
    output logic [BW-1:0]     llc_wr_blk,
    output logic [DW-1:0]     llc_wr_data,
    output logic [BW-1:0]     rd_idx,
    input  dir_st_e           rd_st,
    input  logic [NCORES-1:0] rd_sh,
    output logic              we,
    output logic [BW-1:0]     wr_idx,
    output dir_st_e           wr_st,
    output logic [NCORES-1:0] wr_sh
);
    localparam logic [NCORES-1:0] ONE = NCORES'(1);

    // pending fetch context
    logic              wait_q;
    logic [CW-1:0]     pend_core_q;
    logic [BW-1:0]     pend_blk_q;
    rq_kind_e          pend_kind_q;
    logic [NCORES-1:0] pend_owner_q;

    // next values of the registered outputs
    logic              n_rsp, n_msg, n_wr, n_wait;
    logic [CW-1:0]     n_rsp_core;
    logic [DW-1:0]     n_rsp_data, n_wr_data;
    msg_kind_e         n_mkind;
    logic [NCORES-1:0] n_mdest;
    logic [BW-1:0]     n_wr_blk;

    logic [NCORES-1:0] req_oh, others;
    logic [DW-1:0]     cur_data;
    rq_kind_e          kind;

    assign kind       = rq_kind_e'(req_kind);
    assign req_oh     = ONE << req_core;
    assign others     = rd_sh & ~req_oh;
    assign busy       = wait_q;
    assign rd_idx     = req_blk;
    assign llc_rd_blk = req_blk;
    // forward a write still on its way into the shared cache
    assign cur_data   = (llc_wr_en && llc_wr_blk == req_blk) ? llc_wr_data : llc_rd_data;

    always_comb begin
        we         = 1'b0;
        wr_idx     = req_blk;
        wr_st      = rd_st;
        wr_sh      = rd_sh;
        n_rsp      = 1'b0;
        n_rsp_core = req_core;
        n_rsp_data = cur_data;
        n_msg      = 1'b0;
        n_mkind    = MS_NONE;
        n_mdest    = '0;
        n_wr       = 1'b0;
        n_wr_blk   = req_blk;
        n_wr_data  = req_wdata;
        n_wait     = wait_q;
        if (wait_q) begin
            if (own_valid) begin
                we         = 1'b1;
                wr_idx     = pend_blk_q;
                if (pend_kind_q == RQ_WRITE) begin
                    wr_st = DIR_EXC;
                    wr_sh = ONE << pend_core_q;
                end else begin
                    wr_st = DIR_SHR;
                    wr_sh = pend_owner_q | (ONE << pend_core_q);
                end
                n_rsp      = 1'b1;
                n_rsp_core = pend_core_q;
                n_rsp_data = own_data;
                n_wr       = 1'b1;
                n_wr_blk   = pend_blk_q;
                n_wr_data  = own_data;
                n_wait     = 1'b0;
            end
        end else if (req_valid) begin
            case (kind)
                RQ_READ, RQ_WRITE: begin
                    if (rd_st == DIR_EXC) begin
                        n_msg   = 1'b1;
                        n_mkind = owner_msg(kind);
                        n_mdest = rd_sh;
                        n_wait  = 1'b1;
                    end else begin
                        n_rsp = 1'b1;
                        we    = 1'b1;
                        if (kind == RQ_READ) begin
                            wr_st = DIR_SHR;
                            wr_sh = (rd_st == DIR_UNC) ? req_oh : (rd_sh | req_oh);
                        end else begin
                            wr_st = DIR_EXC;
                            wr_sh = req_oh;
                            if (rd_st == DIR_SHR && others != '0) begin
                                n_msg   = 1'b1;
                                n_mkind = MS_INV;
                                n_mdest = others;
                            end
                        end
                    end
                end
                RQ_WBACK: begin
                    if (rd_st == DIR_EXC && rd_sh == req_oh) begin
                        we    = 1'b1;
                        wr_st = DIR_UNC;
                        wr_sh = '0;
                        n_wr  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q       <= 1'b0;
            pend_core_q  <= '0;
            pend_blk_q   <= '0;
            pend_kind_q  <= RQ_READ;
            pend_owner_q <= '0;
            rsp_valid    <= 1'b0;
            rsp_core     <= '0;
            rsp_data     <= '0;
            msg_valid    <= 1'b0;
            msg_kind     <= MS_NONE;
            msg_dest     <= '0;
            msg_blk      <= '0;
            llc_wr_en    <= 1'b0;
            llc_wr_blk   <= '0;
            llc_wr_data  <= '0;
        end else begin
            wait_q      <= n_wait;
            rsp_valid   <= n_rsp;
            rsp_core    <= n_rsp_core;
            rsp_data    <= n_rsp_data;
            msg_valid   <= n_msg;
            msg_kind    <= n_mkind;
            msg_dest    <= n_mdest;
            msg_blk     <= req_blk;
            llc_wr_en   <= n_wr;
            llc_wr_blk  <= n_wr_blk;
            llc_wr_data <= n_wr_data;
            if (!wait_q && n_wait) begin
                pend_core_q  <= req_core;
                pend_blk_q   <= req_blk;
                pend_kind_q  <= kind;
                pend_owner_q <= rd_sh;
            end
        end
    end

    // a fetch always leaves the controller waiting
    p_fetch_sets_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind != MS_INV) |-> busy);
    // a fetch names a single owner
    p_fetch_one_dest_r6: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind != MS_INV) |-> ($countones(msg_dest) == 1));
    // invalidations accompany a reply and skip the requester
    p_inv_skips_req_r5: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == MS_INV) |->
            (rsp_valid && (msg_dest & (ONE << rsp_core)) == '0));
    // owner data ends the wait with a reply
    p_own_reply_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && own_valid) |=> (rsp_valid && !busy && llc_wr_en));
    // nothing is answered while waiting
    p_quiet_wait_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !own_valid) |=> (!rsp_valid && !msg_valid));
endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
    import coh_dir_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int NBLK   = 16,
    parameter int DW     = 32,
    localparam int CW    = (NCORES > 1) ? $clog2(NCORES) : 1,
    localparam int BW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CW-1:0]     req_core,
    input  logic [BW-1:0]     req_blk,
    input  logic [1:0]        req_kind,
    input  logic [DW-1:0]     req_wdata,
    output logic              busy,
    output logic              msg_valid,
    output logic [1:0]        msg_kind,
    output logic [NCORES-1:0] msg_dest,
    output logic [BW-1:0]     msg_blk,
    input  logic              own_valid,
    input  logic [DW-1:0]     own_data,
    output logic              rsp_valid,
    output logic [CW-1:0]     rsp_core,
    output logic [DW-1:0]     rsp_data,
    output logic [BW-1:0]     llc_rd_blk,
    input  logic [DW-1:0]     llc_rd_data,
    output logic              llc_wr_en,
    output logic [BW-1:0]     llc_wr_blk,
    output logic [DW-1:0]     llc_wr_data
);
    logic [BW-1:0]     rd_idx, wr_idx;
    dir_st_e           rd_st, wr_st;
    logic [NCORES-1:0] rd_sh, wr_sh;
    logic              we;

    coh_dir_store #(.NCORES(NCORES), .NBLK(NBLK)) store_i (
        .clk(clk), .rst(rst),
        .rd_idx(rd_idx), .rd_st(rd_st), .rd_sh(rd_sh),
        .we(we), .wr_idx(wr_idx), .wr_st(wr_st), .wr_sh(wr_sh)
    );

    coh_dir_engine #(.NCORES(NCORES), .NBLK(NBLK), .DW(DW)) engine_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_core(req_core), .req_blk(req_blk),
        .req_kind(req_kind), .req_wdata(req_wdata), .busy(busy),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dest(msg_dest),
        .msg_blk(msg_blk), .own_valid(own_valid), .own_data(own_data),
        .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_data(rsp_data),
        .llc_rd_blk(llc_rd_blk), .llc_rd_data(llc_rd_data),
        .llc_wr_en(llc_wr_en), .llc_wr_blk(llc_wr_blk), .llc_wr_data(llc_wr_data),
        .rd_idx(rd_idx), .rd_st(rd_st), .rd_sh(rd_sh),
        .we(we), .wr_idx(wr_idx), .wr_st(wr_st), .wr_sh(wr_sh)
    );
endmodule

// File: tb/coh_dir_ctrl_tb.sv
`timescale 1ns/1ps
module coh_dir_ctrl_tb_top;
    localparam int NC = 4;
    localparam int NB = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_core = '0;
    logic [3:0]  req_blk = '0;
    logic [1:0]  req_kind = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, msg_valid, rsp_valid, llc_wr_en;
    logic [1:0]  msg_kind, rsp_core;
    logic [3:0]  msg_dest, msg_blk, llc_rd_blk, llc_wr_blk;
    logic        own_valid = 1'b0;
    logic [31:0] own_data = '0;
    logic [31:0] rsp_data, llc_rd_data, llc_wr_data;

    logic [31:0] llc_arr [NB];
    int          ref_st  [NB];   // 0 uncached, 1 shared, 2 exclusive
    logic [3:0]  ref_sh  [NB];
    logic [31:0] ref_dat [NB];
    logic [31:0] last_rsp;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    assign llc_rd_data = llc_arr[llc_rd_blk];
    always @(posedge clk) if (llc_wr_en) llc_arr[llc_wr_blk] <= llc_wr_data;

    coh_dir_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_core(req_core),
        .req_blk(req_blk), .req_kind(req_kind), .req_wdata(req_wdata),
        .busy(busy), .msg_valid(msg_valid), .msg_kind(msg_kind),
        .msg_dest(msg_dest), .msg_blk(msg_blk), .own_valid(own_valid),
        .own_data(own_data), .rsp_valid(rsp_valid), .rsp_core(rsp_core),
        .rsp_data(rsp_data), .llc_rd_blk(llc_rd_blk), .llc_rd_data(llc_rd_data),
        .llc_wr_en(llc_wr_en), .llc_wr_blk(llc_wr_blk), .llc_wr_data(llc_wr_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called just after a falling edge; returns just after a falling edge
    task automatic issue(input int core, input int blk, input int kind, input logic [31:0] wd);
        int st = ref_st[blk];
        logic [3:0] sh = ref_sh[blk];
        logic [3:0] oh = 4'(1) << core;
        logic exp_rsp = 1'b0, exp_msg = 1'b0, exp_wr = 1'b0, exp_wait = 1'b0;
        logic [1:0] exp_mk = 2'd0;
        logic [3:0] exp_md = '0;
        string tag = "R1";
        if (kind == 0 && st == 0) begin tag = "R2"; exp_rsp = 1; end
        else if (kind == 0 && st == 1) begin tag = "R3"; exp_rsp = 1; end
        else if (kind == 1 && st == 0) begin tag = "R4"; exp_rsp = 1; end
        else if (kind == 1 && st == 1) begin
            tag = "R5"; exp_rsp = 1;
            if ((sh & ~oh) != 0) begin exp_msg = 1; exp_mk = 2'd1; exp_md = sh & ~oh; end
        end
        else if (kind == 0 && st == 2) begin tag = "R6"; exp_msg = 1; exp_mk = 2'd2; exp_md = sh; exp_wait = 1; end
        else if (kind == 1 && st == 2) begin tag = "R7"; exp_msg = 1; exp_mk = 2'd3; exp_md = sh; exp_wait = 1; end
        else if (kind == 2) begin tag = "R8"; exp_wr = (st == 2 && sh == oh); end
        req_valid = 1'b1; req_core = 2'(core); req_blk = 4'(blk);
        req_kind = 2'(kind); req_wdata = wd;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'(exp_rsp));
        chk({tag, " msg_valid"}, 32'(msg_valid), 32'(exp_msg));
        chk({tag, " llc_wr_en"}, 32'(llc_wr_en), 32'(exp_wr));
        chk({tag, " busy"}, 32'(busy), 32'(exp_wait));
        if (exp_rsp) begin
            chk({tag, " rsp_core"}, 32'(rsp_core), 32'(core));
            chk({tag, " rsp_data"}, rsp_data, ref_dat[blk]);
            last_rsp = rsp_data;
        end
        if (exp_msg) begin
            chk({tag, " msg_kind"}, 32'(msg_kind), 32'(exp_mk));
            chk({tag, " msg_dest"}, 32'(msg_dest), 32'(exp_md));
            chk({tag, " msg_blk"}, 32'(msg_blk), 32'(blk));
        end
        if (exp_wr) begin
            chk({tag, " llc_wr"}, llc_wr_data, wd);
            ref_dat[blk] = wd; ref_st[blk] = 0; ref_sh[blk] = '0;
        end
        if (exp_rsp) begin
            if (kind == 0) begin ref_st[blk] = 1; ref_sh[blk] = sh | oh; end
            else begin ref_st[blk] = 2; ref_sh[blk] = oh; end
        end
        if (exp_wait) begin
            logic [31:0] od;
            if ($urandom_range(0, 1) == 1) begin
                // R9: a request during the wait is not taken
                req_valid = 1'b1; req_core = 2'($urandom_range(0, 3));
                req_blk = 4'($urandom_range(0, NB - 1)); req_kind = 2'd0;
                @(posedge clk); @(negedge clk);
                req_valid = 1'b0;
                chk("R9 stalled rsp", 32'(rsp_valid), 0);
                chk("R9 stalled msg", 32'(msg_valid), 0);
                chk("R9 busy held", 32'(busy), 1);
            end
            od = $urandom;
            own_valid = 1'b1; own_data = od;
            @(posedge clk); @(negedge clk);
            own_valid = 1'b0;
            chk({tag, " own rsp_valid"}, 32'(rsp_valid), 1);
            chk({tag, " own rsp_core"}, 32'(rsp_core), 32'(core));
            chk({tag, " own rsp_data"}, rsp_data, od);
            chk({tag, " own llc_wr"}, {31'(llc_wr_blk), llc_wr_en}, {31'(blk), 1'b1});
            chk({tag, " own llc_data"}, llc_wr_data, od);
            chk("R9 busy released", 32'(busy), 0);
            ref_dat[blk] = od;
            if (kind == 0) begin ref_st[blk] = 1; ref_sh[blk] = sh | oh; end
            else begin ref_st[blk] = 2; ref_sh[blk] = oh; end
        end
    endtask

    function automatic int pick_core(int blk);
        if (ref_st[blk] == 2 && $urandom_range(0, 3) != 0)
            for (int c = 0; c < NC; c++) if (ref_sh[blk][c]) return c;
        return $urandom_range(0, NC - 1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < NB; i++) begin
            llc_arr[i] = 32'hC0DE_0000 + 32'(i);
            ref_dat[i] = 32'hC0DE_0000 + 32'(i);
            ref_st[i] = 0; ref_sh[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 msg_valid", 32'(msg_valid), 0);
        chk("R1 llc_wr_en", 32'(llc_wr_en), 0);
        // directed
        issue(0, 3, 0, '0);              // R2
        issue(1, 3, 0, '0);              // R3
        issue(2, 3, 1, '0);              // R5 invalidate 0 and 1
        issue(1, 3, 0, '0);              // R6 fetch from 2
        issue(2, 5, 1, '0);              // R4
        issue(3, 5, 1, '0);              // R7
        issue(3, 5, 2, 32'h1234_5678);   // R8 owner write-back
        issue(0, 5, 0, '0);              // R11 read right behind the write
        chk("R11 forwarded data", last_rsp, 32'h1234_5678);
        issue(1, 5, 2, 32'hDEAD_0001);   // R8 ignored, block shared
        issue(2, 7, 1, '0);
        issue(0, 7, 2, 32'hDEAD_0002);   // R8 ignored, not owner
        issue(2, 7, 2, 32'h0BAD_F00D);   // R8 accepted
        // R10 owner data while idle
        own_valid = 1'b1; own_data = 32'hFFFF_0000;
        @(posedge clk); @(negedge clk);
        own_valid = 1'b0;
        chk("R10 no reply", 32'(rsp_valid), 0);
        chk("R10 no write", 32'(llc_wr_en), 0);
        issue(1, 7, 0, '0);              // R10 data unchanged
        chk("R10 data kept", last_rsp, 32'h0BAD_F00D);
        // random traffic
        for (int n = 0; n < 600; n++) begin
            int b = $urandom_range(0, 5);
            int k = $urandom_range(0, 9);
            int kind = (k < 4) ? 0 : (k < 7) ? 1 : 2;
            issue(pick_core(b), b, kind, $urandom);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule